// File: doc/BRIEF.md
# Streamed-Increment Flash Programming Sequencer

This block writes a complete image into a serial NOR flash using the device's self-incrementing program mode, with no software in the loop. After a start pulse it enables writes and erases the whole chip. It waits out the erase by reading the status register, then enables writes again. It sends one opening program command that carries a three-byte start address and the first two image bytes. After that it sends a run of short program commands that carry only the opcode and the next two bytes, because the flash steps its own address forward. A status poll runs after every command. When the image is used up it disables writes and pulses `done`.

Image bytes arrive on a ready/valid byte stream and are packed into pairs. An odd image length is completed with a 0xFF filler byte. Each command goes to an external SPI byte engine through a request/acknowledge interface. That engine handles bit timing and returns the status byte for reads. A programmable limit on consecutive busy status reads stops a stuck erase or program step. The block then jumps to the write-disable step and raises an error flag.

Top module: `aai_prog_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `err`, `eng_req` and `s_ready` are all low until a start is accepted.
- R2: An accepted start first issues write-enable (opcode 0x06) and then chip erase (opcode 0xC7), both with a payload length of 0 and `eng_rd` low.
- R3: A status read uses opcode 0x05, a payload length of 0 and `eng_rd` high. Only bit 0 of the returned byte means busy: bits 7..1 are ignored. Status reads repeat until bit 0 reads 0.
- R4: After the acknowledge of an erase, of a program command or of a status read that returned busy, `eng_req` stays low for exactly GAP_CYC+1 cycles before the next status read is requested.
- R5: Once the erase poll clears on a non-empty image, write-enable (0x06) is issued. It is followed by one program command with opcode 0xAD and payload length 5: address bits 23:16, 15:8 and 7:0, then image bytes 0 and 1. Payload byte k is carried in `eng_wdata[39-8k -: 8]`.
- R6: Every later program command uses opcode 0xAD and payload length 2, with no address. It carries the next two image bytes in stream order, in `eng_wdata[39:24]`.
- R7: For an odd image length, the second byte of the final pair is 0xFF. Over a completed run the stream accepts exactly `img_len` bytes.
- R8: When the poll after the final pair clears, write-disable (0x04, length 0) is issued. `done` is high for exactly the one cycle after its acknowledge, and `busy` is low in that cycle.
- R9: With `img_len` of 0 the sequence is write-enable, erase, the erase poll, then write-disable. No program command is sent and no stream byte is taken.
- R10: When the count of consecutive busy status reads reaches `poll_limit`, no further command of that phase is sent. Write-disable follows next, and `err` is high along with `done`. `err` holds until the next accepted start clears it.
- R11: Once `eng_req` is raised, it and the command fields stay unchanged until the cycle of `eng_ack`.
- R12: A start pulse or a change of `img_len` while a run is in progress has no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| img_len | input | LEN_W | Image length in bytes, latched at start |
| base_addr | input | 24 | Flash start address, latched at start |
| poll_limit | input | LIM_W | Busy-read limit before abort, latched at start |
| s_valid | input | 1 | Image byte valid |
| s_data | input | 8 | Image byte |
| s_ready | output | 1 | Image byte accepted when high with s_valid |
| eng_req | output | 1 | Command request to the SPI byte engine |
| eng_op | output | 8 | Command opcode |
| eng_len | output | 3 | Number of payload bytes after the opcode |
| eng_wdata | output | 40 | Payload, byte k at bits 39-8k down |
| eng_rd | output | 1 | Command returns one status byte |
| eng_ack | input | 1 | One-cycle command completion |
| eng_rdata | input | 8 | Status byte, valid with eng_ack |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Poll-limit abort flag |

## Verification
Each command is held on the request lines until acknowledged, and it takes effect at the acknowledge edge. The bench engine model therefore logs a command at the first falling edge where the request is high, and it checks that the fields stay put through the falling edge that raises the acknowledge. Status reads come exactly GAP_CYC+1 falling edges after the previous acknowledge, so the model counts low-request edges and compares that count against that value for every read. `done` and `err` are sampled at the first falling edge after the write-disable acknowledge, `done` is sampled again one edge later, and the count of stream bytes accepted is read a few idle cycles after the end of the run.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;

  localparam int unsigned ADDR_W = 24;
  localparam int unsigned PAY_W  = 40;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_ERASE = 8'hC7;
  localparam logic [7:0] OP_AAI   = 8'hAD;

  localparam int unsigned STAT_BUSY_BIT = 0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_ERASE,
    ST_GAP,
    ST_RDSR,
    ST_FETCH,
    ST_AAI,
    ST_WRDI,
    ST_DONE
  } seq_state_e;

  typedef enum logic {
    PH_ERASE,
    PH_PROG
  } seq_phase_e;

endpackage

// File: rtl/aai_pair_pack.sv
module aai_pair_pack #(
  parameter int unsigned LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             pair_valid,
  output logic [15:0]      pair_data,
  input  logic             pair_take
);

  logic [LEN_W-1:0] rem_q, rem_d;
  logic [1:0]       fill_q, fill_d;
  logic [15:0]      buf_q, buf_d;
  logic             accept;

  assign s_ready    = (rem_q != '0) && (fill_q != 2'd2);
  assign accept     = s_valid && s_ready;
  assign pair_valid = (fill_q == 2'd2) || ((fill_q == 2'd1) && (rem_q == '0));
  assign pair_data  = (fill_q == 2'd2) ? buf_q : {buf_q[15:8], 8'hFF};

  always_comb begin
    rem_d  = rem_q;
    fill_d = fill_q;
    buf_d  = buf_q;
    if (load) begin
      rem_d  = load_len;
      fill_d = 2'd0;
    end else if (pair_take) begin
      fill_d = 2'd0;
    end else if (accept) begin
      rem_d  = rem_q - 1'b1;
      fill_d = fill_q + 2'd1;
      if (fill_q == 2'd0) buf_d[15:8] = s_data;
      else                buf_d[7:0]  = s_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      fill_q <= 2'd0;
      buf_q  <= 16'h0000;
    end else begin
      rem_q  <= rem_d;
      fill_q <= fill_d;
      buf_q  <= buf_d;
    end
  end

  // R7: the sequencer only consumes a pair that is complete
  a_r7_take_complete: assert property (@(posedge clk) disable iff (!rst_n)
    pair_take |-> pair_valid);

  // R7: a held pair is not disturbed by the stream
  a_r7_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_take && !load) |=> pair_valid && $stable(pair_data));

endmodule

// File: rtl/aai_poll_timer.sv
module aai_poll_timer #(
  parameter int unsigned GAP_CYC = 1000,
  parameter int unsigned LIM_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  output logic             gap_done,
  input  logic             busy_seen,
  input  logic             poll_clr,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);

  localparam int unsigned GAP_W = (GAP_CYC < 1) ? 1 : $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYC);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [LIM_W-1:0] poll_q, poll_d;
  logic [LIM_W:0]   poll_next;

  assign gap_done  = (gap_q == '0);
  assign poll_next = {1'b0, poll_q} + 1'b1;
  assign expire    = busy_seen && (poll_next >= {1'b0, limit});

  always_comb begin
    gap_d = gap_q;
    if (arm)                gap_d = GAP_LOAD;
    else if (gap_q != '0)   gap_d = gap_q - 1'b1;
  end

  always_comb begin
    poll_d = poll_q;
    if (poll_clr)                    poll_d = '0;
    else if (busy_seen && !expire)   poll_d = poll_next[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else begin
      gap_q  <= gap_d;
      poll_q <= poll_d;
    end
  end

  // R10: the busy-read count stays below the limit that ends the phase
  a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_q != '0) |-> (poll_q < limit));

  // R4: once armed, the wait counter only runs downward to zero
  a_r4_gap_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && gap_q != '0) |=> (gap_q == $past(gap_q) - 1'b1));

endmodule

// File: rtl/aai_seq_ctrl.sv
module aai_seq_ctrl
  import aai_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 20,
  parameter int unsigned LIM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   img_len,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [LIM_W-1:0]   poll_limit,
  output logic               cfg_load,
  input  logic               pair_valid,
  input  logic [15:0]        pair_data,
  output logic               pair_take,
  output logic               gap_arm,
  input  logic               gap_done,
  output logic               busy_seen,
  output logic               poll_clr,
  input  logic               expire,
  output logic [LIM_W-1:0]   lim_out,
  output logic               eng_req,
  output logic [7:0]         eng_op,
  output logic [2:0]         eng_len,
  output logic [PAY_W-1:0]   eng_wdata,
  output logic               eng_rd,
  input  logic               eng_ack,
  input  logic [7:0]         eng_rdata,
  output logic               busy,
  output logic               done,
  output logic               err
);

  seq_state_e        state_q, state_d;
  seq_phase_e        phase_q, phase_d;
  logic              first_q, first_d;
  logic [LEN_W:0]    pos_q, pos_d;
  logic              err_q, err_d;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LIM_W-1:0]  lim_q;
  logic              stat_busy;
  logic              clear_seen;
  logic              img_done;
  logic [6:0]        unused_stat;

  assign stat_busy   = eng_rdata[STAT_BUSY_BIT];
  assign unused_stat = eng_rdata[7:1];
  assign cfg_load    = start && (state_q == ST_IDLE);
  assign busy_seen   = (state_q == ST_RDSR) && eng_ack && stat_busy;
  assign clear_seen  = (state_q == ST_RDSR) && eng_ack && !stat_busy;
  assign poll_clr    = cfg_load || clear_seen;
  assign gap_arm     = (eng_ack && ((state_q == ST_ERASE) || (state_q == ST_AAI)))
                     || (busy_seen && !expire);
  assign pair_take   = (state_q == ST_AAI) && eng_ack;
  assign img_done    = (pos_q >= {1'b0, len_q});
  assign lim_out     = lim_q;
  assign busy        = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done        = (state_q == ST_DONE);
  assign err         = err_q;

  // command presented to the byte engine
  always_comb begin
    eng_req   = 1'b0;
    eng_op    = OP_WREN;
    eng_len   = 3'd0;
    eng_rd    = 1'b0;
    eng_wdata = '0;
    case (state_q)
      ST_WREN:  eng_req = 1'b1;
      ST_ERASE: begin eng_req = 1'b1; eng_op = OP_ERASE; end
      ST_RDSR:  begin eng_req = 1'b1; eng_op = OP_RDSR; eng_rd = 1'b1; end
      ST_WRDI:  begin eng_req = 1'b1; eng_op = OP_WRDI; end
      ST_AAI: begin
        eng_req = 1'b1;
        eng_op  = OP_AAI;
        if (first_q) begin
          eng_len   = 3'd5;
          eng_wdata = {addr_q, pair_data};
        end else begin
          eng_len   = 3'd2;
          eng_wdata = {pair_data, 24'h000000};
        end
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    first_d = first_q;
    pos_d   = pos_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_WREN;
          phase_d = PH_ERASE;
          first_d = 1'b1;
          pos_d   = '0;
          err_d   = 1'b0;
        end
      end
      ST_WREN:  if (eng_ack) state_d = (phase_q == PH_ERASE) ? ST_ERASE : ST_FETCH;
      ST_ERASE: if (eng_ack) state_d = ST_GAP;
      ST_GAP:   if (gap_done) state_d = ST_RDSR;
      ST_RDSR: begin
        if (eng_ack) begin
          if (stat_busy) begin
            if (expire) begin
              err_d   = 1'b1;
              state_d = ST_WRDI;
            end else begin
              state_d = ST_GAP;
            end
          end else if (phase_q == PH_ERASE) begin
            if (len_q == '0) begin
              state_d = ST_WRDI;
            end else begin
              phase_d = PH_PROG;
              state_d = ST_WREN;
            end
          end else begin
            state_d = img_done ? ST_WRDI : ST_FETCH;
          end
        end
      end
      ST_FETCH: if (pair_valid) state_d = ST_AAI;
      ST_AAI: begin
        if (eng_ack) begin
          first_d = 1'b0;
          pos_d   = pos_q + (LEN_W+1)'(2);
          state_d = ST_GAP;
        end
      end
      ST_WRDI: if (eng_ack) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ERASE;
      first_q <= 1'b0;
      pos_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      first_q <= first_d;
      pos_q   <= pos_d;
      err_q   <= err_d;
    end
  end

  // run configuration, captured only when a start is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      addr_q <= '0;
      lim_q  <= '0;
    end else if (cfg_load) begin
      len_q  <= img_len;
      addr_q <= base_addr;
      lim_q  <= poll_limit;
    end
  end

  // R11: a raised request holds its command until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> eng_req && $stable(eng_op) && $stable(eng_len)
                              && $stable(eng_wdata) && $stable(eng_rd));

  // R3: status reads carry no payload and expect a returned byte
  a_r3_status_form: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op == OP_RDSR) |-> (eng_rd && eng_len == 3'd0));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done follows only the acknowledge of a write-disable
  a_r8_done_after_wrdi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(eng_ack && eng_req && eng_op == OP_WRDI));

  // R12: a start while a run is active never restarts it
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (busy || done));

endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
  import aai_seq_pkg::*;
#(
  parameter int unsigned LEN_W   = 20,
  parameter int unsigned LIM_W   = 16,
  parameter int unsigned GAP_CYC = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   img_len,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [LIM_W-1:0]   poll_limit,
  input  logic               s_valid,
  input  logic [7:0]         s_data,
  output logic               s_ready,
  output logic               eng_req,
  output logic [7:0]         eng_op,
  output logic [2:0]         eng_len,
  output logic [PAY_W-1:0]   eng_wdata,
  output logic               eng_rd,
  input  logic               eng_ack,
  input  logic [7:0]         eng_rdata,
  output logic               busy,
  output logic               done,
  output logic               err
);

  logic             cfg_load;
  logic             pair_valid;
  logic [15:0]      pair_data;
  logic             pair_take;
  logic             gap_arm;
  logic             gap_done;
  logic             busy_seen;
  logic             poll_clr;
  logic             expire;
  logic [LIM_W-1:0] lim_q;

  aai_pair_pack #(.LEN_W(LEN_W)) pack_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_load),
    .load_len   (img_len),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_ready    (s_ready),
    .pair_valid (pair_valid),
    .pair_data  (pair_data),
    .pair_take  (pair_take)
  );

  aai_poll_timer #(.GAP_CYC(GAP_CYC), .LIM_W(LIM_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (gap_arm),
    .gap_done  (gap_done),
    .busy_seen (busy_seen),
    .poll_clr  (poll_clr),
    .limit     (lim_q),
    .expire    (expire)
  );

  aai_seq_ctrl #(.LEN_W(LEN_W), .LIM_W(LIM_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .img_len    (img_len),
    .base_addr  (base_addr),
    .poll_limit (poll_limit),
    .cfg_load   (cfg_load),
    .pair_valid (pair_valid),
    .pair_data  (pair_data),
    .pair_take  (pair_take),
    .gap_arm    (gap_arm),
    .gap_done   (gap_done),
    .busy_seen  (busy_seen),
    .poll_clr   (poll_clr),
    .expire     (expire),
    .lim_out    (lim_q),
    .eng_req    (eng_req),
    .eng_op     (eng_op),
    .eng_len    (eng_len),
    .eng_wdata  (eng_wdata),
    .eng_rd     (eng_rd),
    .eng_ack    (eng_ack),
    .eng_rdata  (eng_rdata),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  // R1: nothing is requested or accepted while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |-> (!eng_req && !s_ready));

endmodule

// File: tb/aai_prog_seq_tb_top.sv
`timescale 1ns/1ps
module aai_prog_seq_tb_top;

  localparam int LEN_W = 12;
  localparam int LIM_W = 8;
  localparam int GAP   = 3;
  localparam int LAT   = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [LEN_W-1:0] img_len;
  logic [23:0]      base_addr;
  logic [LIM_W-1:0] poll_limit;
  logic             s_valid;
  logic [7:0]       s_data;
  logic             s_ready;
  logic             eng_req;
  logic [7:0]       eng_op;
  logic [2:0]       eng_len;
  logic [39:0]      eng_wdata;
  logic             eng_rd;
  logic             eng_ack;
  logic [7:0]       eng_rdata;
  logic             busy;
  logic             done;
  logic             err;

  always #2.5 clk = ~clk;

  aai_prog_seq #(.LEN_W(LEN_W), .LIM_W(LIM_W), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .base_addr(base_addr), .poll_limit(poll_limit),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .eng_req(eng_req), .eng_op(eng_op), .eng_len(eng_len),
    .eng_wdata(eng_wdata), .eng_rd(eng_rd), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata), .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] img_byte(input int i);
    return 8'((i * 29 + 7) & 8'hFF);
  endfunction

  // command logs
  logic [7:0]  lg_op [0:127];
  logic [2:0]  lg_len[0:127];
  logic [39:0] lg_wd [0:127];
  logic        lg_rd [0:127];
  int          lg_n;
  logic [7:0]  ex_op [0:127];
  logic [2:0]  ex_len[0:127];
  logic [39:0] ex_wd [0:127];
  logic        ex_rd [0:127];
  string       ex_tag[0:127];
  int          ex_n;

  // flash / engine model state
  int   cfg_be, cfg_bp;
  int   busy_left;
  bit   mdl_act;
  int   mdl_lat;
  int   lowcnt;
  bit   wrdi_flag;
  bit   done_seen;
  logic [7:0]  cap_op;
  logic [39:0] cap_wd;

  always @(negedge clk) begin
    if (!rst_n) begin
      eng_ack = 1'b0; eng_rdata = 8'h00; mdl_act = 0; lowcnt = 0;
      wrdi_flag = 0; busy_left = 0;
    end else if (eng_ack) begin
      eng_ack = 1'b0;
      if (wrdi_flag) begin
        chk(done == 1'b1, "R8 done after write-disable", done, 1);
        chk(busy == 1'b0, "R8 busy low with done", busy, 0);
        wrdi_flag = 0;
        done_seen = 1;
      end
      if (!eng_req) lowcnt++;
    end else if (mdl_act) begin
      chk(eng_req && eng_op == cap_op && eng_wdata == cap_wd, "R11 request held",
          {eng_req, eng_op}, {1'b1, cap_op});
      mdl_lat--;
      if (mdl_lat == 0) begin
        mdl_act = 0;
        eng_ack = 1'b1;
        eng_rdata = 8'h00;
        if (cap_op == 8'hC7) busy_left = cfg_be;
        if (cap_op == 8'hAD) busy_left = cfg_bp;
        if (cap_op == 8'h04) wrdi_flag = 1;
        if (cap_op == 8'h05) begin
          eng_rdata = (busy_left > 0) ? 8'h41 : 8'hC2;
          if (busy_left > 0) busy_left--;
        end
      end
    end else if (eng_req) begin
      if (lg_n < 128) begin
        lg_op[lg_n] = eng_op; lg_len[lg_n] = eng_len;
        lg_wd[lg_n] = eng_wdata; lg_rd[lg_n] = eng_rd;
        lg_n++;
      end
      if (eng_op == 8'h05)
        chk(lowcnt == GAP + 1, "R4 poll spacing", lowcnt, GAP + 1);
      lowcnt = 0;
      cap_op = eng_op; cap_wd = eng_wdata;
      mdl_act = 1; mdl_lat = LAT;
    end else begin
      lowcnt++;
    end
  end

  // image byte source
  int src_len;
  bit src_on, src_gap, src_clr, src_pend;
  int src_idx, src_cyc;

  always @(negedge clk) begin
    if (!rst_n || src_clr) begin
      src_idx = 0; src_pend = 0; s_valid = 1'b0; s_data = 8'h00; src_cyc = 0;
    end else begin
      if (src_pend) src_idx++;
      src_cyc++;
      s_valid = src_on && (!src_gap || (src_cyc % 3 != 1));
      s_data  = (src_idx < src_len) ? img_byte(src_idx) : 8'hEE;
      src_pend = s_valid && s_ready;
    end
  end

  task automatic push(input logic [7:0] op, input logic [2:0] ln,
                      input logic [39:0] wd, input logic rd, input string tag);
    ex_op[ex_n] = op; ex_len[ex_n] = ln; ex_wd[ex_n] = wd;
    ex_rd[ex_n] = rd; ex_tag[ex_n] = tag; ex_n++;
  endtask

  task automatic add_polls(input int b, input int lim, inout bit abort);
    if (b >= lim) begin
      for (int k = 0; k < lim; k++) push(8'h05, 3'd0, 40'h0, 1'b1, "R10 status read");
      abort = 1;
    end else begin
      for (int k = 0; k <= b; k++) push(8'h05, 3'd0, 40'h0, 1'b1, "R3 status read");
    end
  endtask

  task automatic run_case(input int len, input logic [23:0] base, input int be,
                          input int bp, input int lim, input bit gap, input bit poke);
    bit abort;
    int npairs, exp_acc, cyc, nb;
    logic [7:0] d0, d1;
    logic [39:0] wd;
    abort = 0; npairs = 0; ex_n = 0;
    push(8'h06, 3'd0, 40'h0, 1'b0, "R2 write-enable");
    push(8'hC7, 3'd0, 40'h0, 1'b0, "R2 chip erase");
    add_polls(be, lim, abort);
    if (!abort && len > 0) begin
      push(8'h06, 3'd0, 40'h0, 1'b0, "R5 write-enable");
      for (int p = 0; (2 * p < len) && !abort; p++) begin
        d0 = img_byte(2 * p);
        d1 = (2 * p + 1 < len) ? img_byte(2 * p + 1) : 8'hFF;
        wd = (p == 0) ? {base, d0, d1} : {d0, d1, 24'h0};
        push(8'hAD, (p == 0) ? 3'd5 : 3'd2, wd, 1'b0,
             (2 * p + 1 >= len) ? "R7 final pair" : ((p == 0) ? "R5 first program" : "R6 later program"));
        npairs++;
        add_polls(bp, lim, abort);
      end
    end
    push(8'h04, 3'd0, 40'h0, 1'b0, (len == 0) ? "R9 write-disable" : "R8 write-disable");
    exp_acc = abort ? ((len < 2 * npairs + 2) ? len : 2 * npairs + 2) : len;

    cfg_be = be; cfg_bp = bp; src_len = len; src_gap = gap; src_on = 0;
    src_clr = 1; @(negedge clk); @(negedge clk); src_clr = 0;
    lg_n = 0; done_seen = 0;
    img_len = LEN_W'(len); base_addr = base; poll_limit = LIM_W'(lim);
    start = 1'b1; src_on = 1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(err == 1'b0, "R10 err cleared by start", err, 0);
    cyc = 0;
    while (!done_seen && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 15) begin
        start = 1'b1; img_len = LEN_W'(len + 5);
      end else if (poke && cyc == 16) begin
        start = 1'b0;
      end
    end
    chk(done_seen, "R8 run completes", done_seen, 1);
    chk(err == abort, "R10 err at done", err, abort);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    src_on = 0;
    repeat (3) @(negedge clk);
    chk(err == abort, "R10 err held", err, abort);
    chk(src_idx == exp_acc, (len == 0) ? "R9 bytes taken" : "R7 bytes taken", src_idx, exp_acc);
    chk(lg_n == ex_n, poke ? "R12 command count" : "R2 command count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      chk(lg_op[i] == ex_op[i] && lg_len[i] == ex_len[i] && lg_rd[i] == ex_rd[i],
          ex_tag[i], {lg_op[i], 1'b0, lg_len[i], 3'b0, lg_rd[i]},
          {ex_op[i], 1'b0, ex_len[i], 3'b0, ex_rd[i]});
      nb = ex_len[i];
      for (int k = 0; k < nb; k++)
        chk(lg_wd[i][39 - 8 * k -: 8] == ex_wd[i][39 - 8 * k -: 8], ex_tag[i],
            lg_wd[i][39 - 8 * k -: 8], ex_wd[i][39 - 8 * k -: 8]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; img_len = '0; base_addr = '0; poll_limit = '0;
    src_on = 0; src_gap = 0; src_clr = 0; src_len = 0; cfg_be = 0; cfg_bp = 0;
    lg_n = 0; done_seen = 0;
    repeat (3) @(negedge clk);
    chk({busy, done, err, eng_req, s_ready} == 5'b0, "R1 in reset",
        {busy, done, err, eng_req, s_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, done, err, eng_req, s_ready} == 5'b0, "R1 after reset",
        {busy, done, err, eng_req, s_ready}, 0);

    // sweep image lengths with two busy profiles and two stream patterns
    for (int len = 0; len < 10; len++) begin
      run_case(len, 24'h000000 + 24'(len * 24'h010203), 0, 0, 20, 1'b0, 1'b0);
      run_case(len, 24'hA5_5A_00 ^ 24'(len), 2, 1, 20, 1'b1, 1'b0);
    end
    // start and length change mid-run are ignored
    run_case(7, 24'h123456, 1, 2, 20, 1'b1, 1'b1);
    // busy never clears during erase
    run_case(6, 24'h000100, 100, 0, 4, 1'b0, 1'b0);
    // busy never clears after the first program command
    run_case(8, 24'h7F0000, 1, 100, 3, 1'b1, 1'b0);
    // a normal run afterwards clears the flag
    run_case(5, 24'h00FF00, 3, 2, 4, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule